// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Output Slice

This block serializes one parallel word onto a single output bit, one bit per rising edge of the serial clock, least significant bit first. Its progress through the word shows as a thermometer of stage outputs. A new stage line goes high on every advancing edge and stays high until the word restarts. This chain of stage lines is what lets slices be linked. The first slice of a chain has its chain input tied high, so it starts shifting by itself. Each later slice takes its chain input from a chosen stage line of the slice before it, and starts with its own bit 0 once that line is high.

The total serial word width is set by wiring. The stage line that marks the last bit of the whole word drives the restart input of every slice. On the edge where restart is sampled high, all stage lines drop and the drivers release the bus. On the next edge the first slice captures a new parallel word and sends its bit 0. Each slice drives the shared serial line only in the cycles where it is sending one of its own bits. This means the serial outputs of all slices can be joined on one 1-bit bus.

A typical chain builds a 16-bit word from nine bits of a first slice and seven bits of a second slice. Stage line 8 of the first slice feeds the second slice's chain input. Stage line 6 of the second slice feeds both restart inputs.

Top module: `par2ser_slice`

## Requirements
- R1: A synchronous active-high reset clears every stage output and releases the serial output (`so_oe` low, `so` high impedance).
- R2: A clock edge on which `restart` is high clears every stage output and releases the serial output in the following cycle, whatever the other inputs are.
- R3: A clock edge with `chain_in` high, `restart` low and the top stage line low raises exactly one more stage line, in order from `stage[0]` upward, so `stage` is always a thermometer code (bits 0..n high, the rest low).
- R4: Once `stage[W-1]` is high, later edges without restart leave `stage` unchanged and keep the serial output released.
- R5: While `chain_in` is low, the slice does not advance: a slice that has been reset or restarted keeps all stage outputs low and its serial output released.
- R6: In the cycle where `stage[n]` is the highest line set, `so` carries bit n of the parallel word. That word is captured from `pdata` on the edge that raises `stage[0]`. Bits therefore leave least significant first.
- R7: `so_oe` is high, and `so` is driven, exactly in the cycle after an advancing edge (as defined in R3). In all other cycles `so` is high impedance.
- R8: When two slices are chained as 9 + 7 bits, the joined bus carries exactly 16 driven bits per word, in order, followed by one undriven cycle. At no point are both slices driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial output clock |
| rst | input | 1 | Synchronous active-high reset |
| pdata | input | W | Parallel word, captured when `stage[0]` rises |
| chain_in | input | 1 | Chain input: tie high in the first slice, else connect to a stage line of the previous slice |
| restart | input | 1 | Word restart: connect to the stage line that marks the last bit of the full word |
| stage | output | W | Thermometer of bits sent in the current word |
| so_oe | output | 1 | High while this slice drives the serial bus |
| so | output | 1 | Serial data, high impedance when `so_oe` is low |

## Verification
The assertions take three things for granted. First, `pdata` holds steady from the restart edge until the edge that raises `stage[0]`. Second, `chain_in` rises only as a stage line of an earlier slice or stays tied high. Third, `restart` is the last stage line of the chain, so it is never high while a slice would still need to advance. The bench meets all three by wiring two slices exactly as in the 16-bit chain. It changes the parallel word only during the undriven cycle that follows each restart edge, and sends a reset mid-word only as a separate step, after which it runs a full word again. Inside that wiring it sweeps all-zero, all-one, alternating and every walking-one word, plus a run of scrambled values. In every cycle it compares both stage vectors, both enables and the bus bit with values worked out from the bit position.

// File: rtl/par2ser_slice.sv
module par2ser_slice #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pdata,
  input  logic         chain_in,
  input  logic         restart,
  output logic [W-1:0] stage,
  output logic         so_oe,
  output logic         so
);

  logic [W-1:0] hold;
  logic         bit_q;
  logic         step;

  assign step = chain_in && !restart && !stage[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      so_oe <= 1'b0;
      bit_q <= 1'b0;
      hold  <= '0;
    end else if (restart) begin
      stage <= '0;
      so_oe <= 1'b0;
    end else begin
      so_oe <= step;
      if (step) begin
        stage <= {stage[W-2:0], 1'b1};
        if (!stage[0]) begin
          bit_q <= pdata[0];
          hold  <= pdata >> 1;
        end else begin
          bit_q <= hold[0];
          hold  <= hold >> 1;
        end
      end
    end
  end

  assign so = so_oe ? bit_q : 1'bz;

  assert_thermo_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage + 1'b1));

  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (chain_in && !restart && !stage[W-1]) |=>
      ($countones(stage) == $past($countones(stage)) + 1) && so_oe);

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (stage == '0) && !so_oe);

  assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (stage[W-1] && !restart) |=> $stable(stage) && !so_oe);

  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!chain_in && !restart) |=> $stable(stage) && !so_oe);

  assert_first_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (chain_in && !restart && !stage[0]) |=> (so == $past(pdata[0])));

endmodule

// File: tb/par2ser_slice_test.sv
module par2ser_slice_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] word_in = '0;
  logic [8:0]  st0, st1;
  logic        oe0, oe1, so0, so1, bus;
  logic [8:0]  din_hi;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign din_hi = {2'b00, word_in[15:9]};
  assign bus = oe0 ? so0 : (oe1 ? so1 : 1'b0);

  par2ser_slice #(.W(9)) uut (
    .clk(clk), .rst(rst), .pdata(word_in[8:0]), .chain_in(1'b1),
    .restart(st1[6]), .stage(st0), .so_oe(oe0), .so(so0));

  par2ser_slice #(.W(9)) uut_hi (
    .clk(clk), .rst(rst), .pdata(din_hi), .chain_in(st0[8]),
    .restart(st1[6]), .stage(st1), .so_oe(oe1), .so(so1));

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int w);
    if (w == 0) return 16'h0000;
    if (w == 1) return 16'hFFFF;
    if (w == 2) return 16'hAAAA;
    if (w == 3) return 16'h5555;
    if (w < 20) return 16'h1 << (w - 4);
    return 16'(w * 40503) ^ 16'(w << 3);
  endfunction

  task automatic run_word(input logic [15:0] w, input int nbits);
    int driven = 0;
    word_in = w;
    for (int k = 0; k < nbits; k++) begin
      int e0, e1;
      tick;
      e0 = (k < 9) ? ((1 << (k + 1)) - 1) : 9'h1FF;
      e1 = (k < 9) ? 0 : ((1 << (k - 8)) - 1);
      check("R3_R4 stage lo", int'(st0), e0);
      check("R3_R5 stage hi", int'(st1), e1);
      check("R7 oe lo", int'(oe0), int'(k < 9));
      check("R7 oe hi", int'(oe1), int'(k >= 9));
      check("R8 no contention", int'(oe0 && oe1), 0);
      check("R6 bit", int'(bus), int'(w[k]));
      if (oe0 || oe1) driven++;
    end
    if (nbits == 16) begin
      check("R8 bits per word", driven, 16);
      tick;
      check("R2 gap stage lo", int'(st0), 0);
      check("R2 gap stage hi", int'(st1), 0);
      check("R2 gap released", int'(oe0 || oe1), 0);
    end
  endtask

  initial begin
    repeat (3) tick;
    check("R1 stage lo", int'(st0), 0);
    check("R1 stage hi", int'(st1), 0);
    check("R1 released", int'(oe0 || oe1), 0);
    rst = 1'b0;
    for (int w = 0; w < 60; w++) run_word(pat(w), 16);
    run_word(16'h1234, 12);
    rst = 1'b1;
    tick;
    check("R1 mid-word stage lo", int'(st0), 0);
    check("R1 mid-word stage hi", int'(st1), 0);
    check("R1 mid-word released", int'(oe0 || oe1), 0);
    rst = 1'b0;
    run_word(16'hC3A5, 16);
    run_word(16'h0F0F, 16);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule